// File: doc/BRIEF.md
# Asynchronous Bus Master with Selectable Data Width

This block sits between a processor core and an external bus that has separate address and data lines and an acknowledge-terminated handshake. The core hands over one operand transfer: an address, a size code, a direction and, for writes, the data. The block then runs as many external bus cycles as the operand needs. It drives the address, the direction and the address strobe, and asserts the data strobe or strobes for the byte lanes in use. It keeps each cycle open until the slave acknowledges it.

A width-select input picks the data path. When the input is high, the path is 16 bits. A word then moves in one cycle and a long word in two. A single byte uses the upper or the lower lane according to the address parity. When the input is low, the path is 8 bits. Every cycle uses the lower strobe and lines 7..0 alone, and wider operands are broken into a run of byte cycles. Read data are reassembled with the most significant part first. Completion is reported to the core with a one-cycle pulse.

The acknowledge is asynchronous, so it passes through a two-stage synchronizer before read data are sampled. The master negates its strobes once it sees the acknowledge, and it starts no new cycle while the acknowledge is still asserted.

Top module: `async_bus_master`

## Requirements
- R1: After reset, busy, done, the address strobe and both data strobes are low.
- R2: With the width input low, the upper strobe is never asserted. Each cycle asserts the lower strobe and moves one byte on lines 7..0. Read data on lines 15..8 have no effect on the result.
- R3: With the width input low, size code 0 (byte) takes one bus cycle, size code 1 (word) takes two and size code 2 (long word) takes four.
- R4: With the width input high, a word takes one cycle with both strobes asserted and the full 16 bits on the data lines. A long word takes two such cycles.
- R5: With the width input high, a byte at an even address uses the upper strobe and lines 15..8. A byte at an odd address uses the lower strobe and lines 7..0.
- R6: Operands move most significant part first. Each later cycle of a split operand uses the start address plus the number of bytes already moved.
- R7: A cycle stays open with address strobe, data strobes, address and write data held steady until the acknowledge arrives. The strobes never fall while the acknowledge is low.
- R8: After the acknowledge, the strobes are negated. The next cycle's address strobe does not rise until the acknowledge has been negated.
- R9: Completion of the whole operand gives a done pulse one clock cycle wide. On a read, the output data hold the assembled operand, zero-extended, in that same cycle.
- R10: A request is taken only while busy is low. Requests and changes of the width input during a transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_mode | input | 1 | 1 = 16-bit data path, 0 = 8-bit data path; sampled at request |
| req_valid | input | 1 | Request strobe from the core |
| req_addr | input | ADDR_W | Operand start address |
| req_size | input | 2 | 0 byte, 1 word, 2 long word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read operand |
| bus_addr | output | ADDR_W | External address |
| bus_as | output | 1 | Address strobe, active high |
| bus_uds | output | 1 | Upper data strobe (lines 15..8), active high |
| bus_lds | output | 1 | Lower data strobe (lines 7..0), active high |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Asynchronous slave acknowledge, active high |

## Verification
A wrong remaining-cycle count shows up when the operand completes. The number of address-strobe pulses for that operand is then wrong, and the done pulse comes early or never. A misaligned shift register for reads or writes produces bytes in the wrong order or a wrong lane. The bench compares against its own memory image at every done, so it catches that within the operand. A state machine that ignores the acknowledge level shows up as a strobe falling with the acknowledge low, or a new strobe rising while the acknowledge is still high. The bench slave flags each of these during the offending cycle itself.

// File: rtl/async_bus_master.sv
module async_bus_master #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_as,
  output logic              bus_uds,
  output logic              bus_lds,
  output logic              bus_rw,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din,
  input  logic              bus_ack
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_RECOVER} st_t;

  st_t               st;
  logic              ack_m, ack_s;
  logic              wide_q, wr_q, byte_q;
  logic [2:0]        left;
  logic [31:0]       wbuf, rbuf;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  wire [2:0] n_cyc = wide_mode ? ((req_size == 2'd2) ? 3'd2 : 3'd1)
                               : ((req_size == 2'd2) ? 3'd4 : (req_size == 2'd1) ? 3'd2 : 3'd1);
  wire [4:0] shamt = (req_size == 2'd2) ? 5'd0 : (req_size == 2'd1) ? 5'd16 : 5'd24;
  wire       pair  = wide_q & ~byte_q;
  wire       strb  = (st == S_STROBE);
  wire [7:0] lane  = (wide_q & ~addr_q[0]) ? bus_din[15:8] : bus_din[7:0];

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign rdata    = rbuf;
  assign bus_addr = addr_q;
  assign bus_as   = strb;
  assign bus_uds  = strb & wide_q & (~byte_q | ~addr_q[0]);
  assign bus_lds  = strb & (~wide_q | ~byte_q | addr_q[0]);
  assign bus_rw   = ~(busy & wr_q);
  assign bus_dout = pair   ? wbuf[31:16]
                  : wide_q ? {wbuf[31:24], wbuf[31:24]}
                  :          {8'h00, wbuf[31:24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= bus_ack;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wide_q <= 1'b0;
      wr_q   <= 1'b0;
      byte_q <= 1'b0;
      left   <= '0;
      wbuf   <= '0;
      rbuf   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wide_q <= wide_mode;
          wr_q   <= req_write;
          byte_q <= (req_size == 2'd0);
          left   <= n_cyc;
          wbuf   <= req_wdata << shamt;
          rbuf   <= '0;
          addr_q <= req_addr;
          st     <= S_SETUP;
        end
        S_SETUP: st <= S_STROBE;
        S_STROBE: if (ack_s) begin
          rbuf <= pair ? {rbuf[15:0], bus_din} : {rbuf[23:0], lane};
          wbuf <= pair ? (wbuf << 16) : (wbuf << 8);
          left <= left - 3'd1;
          st   <= S_RECOVER;
        end
        S_RECOVER: if (!ack_s) begin
          if (left == 3'd0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            addr_q <= addr_q + (pair ? ADDR_W'(2) : ADDR_W'(1));
            st     <= S_SETUP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  narrow_no_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> !bus_uds);

  // R7
  strobe_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_uds || bus_lds) |-> bus_as);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_dout) && $stable(bus_rw)));

  // R8
  no_start_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as) |-> !ack_s);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wide_q));

endmodule

// File: tb/sim_async_bus_master.sv
`timescale 1ns/1ps
module sim_async_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        busy, done;
  logic [31:0] rdata;
  logic [31:0] bus_addr;
  logic        bus_as, bus_uds, bus_lds, bus_rw;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 16'hDEAD;
  logic        bus_ack = 1'b0;

  always #2 clk = ~clk;

  async_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_as(bus_as), .bus_uds(bus_uds), .bus_lds(bus_lds),
    .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  typedef struct {
    logic        rd;
    logic [31:0] data;
    int          cyc;
    string       tag;
  } item_t;

  item_t      sb[$];
  int         checks = 0;
  int         errors = 0;
  int         ncyc = 0;
  int         viol_uds = 0, viol_ack = 0, viol_early = 0;
  logic       mode_tb = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] ref_m [256];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus slave with varying response latency
  always begin
    int a;
    int lat;
    @(posedge bus_as);
    ncyc++;
    if (bus_ack) viol_ack++;
    if (!mode_tb && bus_uds) viol_uds++;
    a = int'(bus_addr[7:0]);
    lat = 5 + ((ncyc * 7 + a) % 37);
    #(lat);
    if (!bus_rw) begin
      if (!mode_tb) mem[a] = bus_dout[7:0];
      else begin
        if (bus_uds) mem[a & 8'hFE] = bus_dout[15:8];
        if (bus_lds) mem[a | 1] = bus_dout[7:0];
      end
    end else begin
      if (!mode_tb) bus_din = {8'hEE, mem[a]};
      else bus_din = {bus_uds ? mem[a & 8'hFE] : 8'hEE, bus_lds ? mem[a | 1] : 8'hEE};
    end
    bus_ack = 1'b1;
    @(negedge bus_as);
    #15;
    bus_ack = 1'b0;
    bus_din = 16'hDEAD;
  end

  // R7: strobes must not fall before acknowledge
  always @(negedge bus_as) if (!bus_ack) viol_early++;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk("R9 unexpected done", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        if (it.rd) chk({it.tag, " R9 R6 read data"}, rdata, it.data);
        chk({it.tag, " R3 R4 cycle count"}, 32'(ncyc), 32'(it.cyc));
      end
    end
  end

  task automatic op(input logic wide, input logic [1:0] sz, input logic wr,
                    input logic [7:0] addr, input logic [31:0] wd, input string tag,
                    input logic poke);
    item_t it;
    int nb;
    logic [31:0] e;
    nb = (sz == 2'd2) ? 4 : (sz == 2'd1) ? 2 : 1;
    e = '0;
    for (int i = 0; i < nb; i++) begin
      if (wr) ref_m[addr + 8'(i)] = wd[(nb-1-i)*8 +: 8];
      e = (e << 8) | 32'(ref_m[addr + 8'(i)]);
    end
    it.rd = !wr;
    it.data = e;
    it.cyc = wide ? ((sz == 2'd2) ? 2 : 1) : nb;
    it.tag = tag;
    @(negedge clk);
    ncyc = 0;
    mode_tb = wide;
    wide_mode = wide;
    sb.push_back(it);
    req_valid = 1'b1; req_addr = {24'h0, addr}; req_size = sz;
    req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      wide_mode = ~wide;
      req_valid = 1'b1; req_addr = 32'h0000_0080; req_size = 2'd2; req_write = 1'b1;
      req_wdata = 32'hBADBADBA;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    if (wr) for (int i = 0; i < nb; i++)
      chk({tag, " R6 write byte"}, 32'(mem[addr + 8'(i)]), 32'(ref_m[addr + 8'(i)]));
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_m[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 as", 32'(bus_as), 0);
    chk("R1 strobes", 32'({bus_uds, bus_lds}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 narrow path
    op(1'b0, 2'd0, 1'b0, 8'h11, 32'h0, "R2 narrow byte rd", 1'b0);
    op(1'b0, 2'd1, 1'b0, 8'h21, 32'h0, "R3 narrow word rd", 1'b0);
    op(1'b0, 2'd2, 1'b0, 8'h33, 32'h0, "R3 narrow long rd", 1'b0);
    op(1'b0, 2'd2, 1'b1, 8'h41, 32'hA1B2C3D4, "R6 narrow long wr", 1'b0);
    op(1'b0, 2'd2, 1'b0, 8'h41, 32'h0, "R6 narrow long rdback", 1'b0);
    op(1'b0, 2'd1, 1'b1, 8'h50, 32'h0000_5A6B, "R3 narrow word wr", 1'b0);

    // R4 R5 wide path
    op(1'b1, 2'd1, 1'b0, 8'h60, 32'h0, "R4 wide word rd", 1'b0);
    op(1'b1, 2'd2, 1'b0, 8'h64, 32'h0, "R4 wide long rd", 1'b0);
    op(1'b1, 2'd2, 1'b1, 8'h70, 32'h1357_9BDF, "R4 wide long wr", 1'b0);
    op(1'b1, 2'd0, 1'b0, 8'h72, 32'h0, "R5 wide even byte rd", 1'b0);
    op(1'b1, 2'd0, 1'b0, 8'h75, 32'h0, "R5 wide odd byte rd", 1'b0);
    op(1'b1, 2'd0, 1'b1, 8'h90, 32'h0000_00C5, "R5 wide even byte wr", 1'b0);
    op(1'b1, 2'd0, 1'b1, 8'h93, 32'h0000_007E, "R5 wide odd byte wr", 1'b0);
    chk("R5 neighbour of even byte untouched", 32'(mem[8'h91]), 32'(ref_m[8'h91]));
    chk("R5 neighbour of odd byte untouched", 32'(mem[8'h92]), 32'(ref_m[8'h92]));

    // R10 request and width change during a transfer are ignored
    op(1'b0, 2'd2, 1'b0, 8'hA0, 32'h0, "R10 narrow long with poke", 1'b1);
    repeat (40) @(negedge clk);
    chk("R10 no extra cycles after done", 32'(ncyc), 32'd4);
    chk("R10 idle after poke", 32'(busy), 0);
    chk("R10 poked address untouched", 32'(mem[8'h80]), 32'(ref_m[8'h80]));
    op(1'b1, 2'd2, 1'b1, 8'hB0, 32'hCAFE_F00D, "R10 wide long wr with poke", 1'b1);

    // bus protocol observations
    chk("R2 upper strobe in narrow mode", 32'(viol_uds), 0);
    chk("R8 strobe rose with ack high", 32'(viol_ack), 0);
    chk("R7 strobe fell before ack", 32'(viol_early), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule